// File: doc/BRIEF.md
# MDIO management master

This block is a register-driven management master for the two-wire PHY management bus, using clause 22 frames. Software writes one user-access word to describe a PHY register access: direction, PHY address, register number and, for a write, the data. The block shifts the complete frame out on MDC and MDIO and holds a go flag high for the whole frame. When the frame is over, the block clears the go flag.

After a read, the same word holds the 16 bits returned by the PHY. It also holds a flag that shows whether the PHY answered in the turnaround slot. A control word holds four things: an enable bit, the MDC divider, a fault-detect enable and a sticky fault flag. Its top bit reads back as an idle status. The fault flag is set when the level seen on the wire differs from the level the block is driving.

The register port has a one-bit select (0 = control word, 1 = user-access word), a write strobe, write data and combinational read data. The bus side has MDC, MDIO data out, MDIO output enable and MDIO data in.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control word reads 0x800000FF: idle bit 31 = 1, enable bit 30 = 0, fault bit 19 = 0, fault-enable bit 18 = 0, divider bits 15:0 = 0xFF. The user-access word reads 0. MDC and the MDIO output enable are low.
- R2: Select 0 is the control word. Bits 30, 18 and 15:0 are writable and read back as written. Bit 31 reads idle. Select 1 is the user-access word: go is bit 31, direction is bit 30 (1 = write), acknowledge is bit 29, register number is bits 25:21, PHY address is bits 20:16 and data is bits 15:0.
- R3: A write to the user-access word with bit 31 = 1, while enable is 1 and go is 0, starts a frame. Go reads 1 until the frame ends and then 0. Control bit 31 reads the complement of go.
- R4: Sampled at MDC rising edges, a frame carries 64 bits in this order: 32 ones, then 01, then opcode 01 for a write or 10 for a read, then the 5-bit PHY address, then the 5-bit register number, then two turnaround bits (10 on a write), then 16 data bits. All fields are sent MSB first.
- R5: One MDC period lasts max(divider,1)+1 clock cycles. MDC stays low when no frame is running.
- R6: MDIO output changes only while MDC is low, at the MDC falling edge. It is steady while MDC is high. MDIO input is sampled at the MDC rising edge.
- R7: In a read frame the output enable is low for bits 46 through 63. At the end of the read, bits 15:0 take the 16 sampled bits. The acknowledge bit becomes 1 if the PHY drove 0 in bit 47, and 0 otherwise.
- R8: While go is 1, writes to the user-access word have no effect.
- R9: While enable is 0, a go write starts nothing and MDC stays low. Clearing enable during a frame ends it at the next clock: go clears, MDC and the output enable go low, and idle reads 1.
- R10: When bit 18 is 1, bit 19 is set if MDIO input differs from the driven MDIO output at an MDC rising edge while the output is enabled. Writing 1 to bit 19 clears it. When bit 18 is 0, bit 19 is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 control, 1 user-access |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data driven by the block |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data seen on the wire |

## Verification
The assertions check several rules on every cycle:
- MDC is low whenever enable is off or no frame is running.
- The data line never moves while MDC is high.
- The output enable is released through the turnaround and data bits of a read.
- The address fields hold steady while go is high.
- The fault flag stays set until it is cleared.

Other behaviour can only be shown by the bench scenarios, which compare each frame with a queued expectation. These cover the exact bit order of a frame, the MDC period at several divider values, and the returned read data with its acknowledge flag for a responding PHY and for a silent one. They also cover fault capture under a forced line conflict and the abort on a cleared enable.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter logic [15:0] DIV_RST = 16'h00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int FRAME_BITS = 64;
  localparam logic [5:0] LAST_IDX = 6'(FRAME_BITS - 1);
  localparam logic [5:0] TA2_IDX = 6'd47;
  localparam logic [5:0] DATA_IDX = 6'd48;
  localparam logic [5:0] REL_IDX = 6'd46;

  logic        en, flt, flt_en;
  logic [15:0] div;
  logic        go, wr_dir, ack, ta_smp;
  logic [4:0]  ra, pa;
  logic [15:0] dat, rd;
  logic [15:0] cnt;
  logic [5:0]  idx;
  logic [63:0] sh;
  logic        mdc_q, mdo_q, oe_q;

  logic [15:0] dv, hdiv;
  logic        rise, fall, ctrl_wr, usr_wr, start;
  logic        unused_wbits;

  assign dv      = (div == 16'd0) ? 16'd1 : div;
  assign hdiv    = dv >> 1;
  assign rise    = go & en & (cnt == hdiv);
  assign fall    = go & en & (cnt == dv);
  assign ctrl_wr = reg_we & ~reg_sel;
  assign usr_wr  = reg_we & reg_sel & ~go;
  assign start   = usr_wr & reg_wdata[31] & en;
  assign unused_wbits = ^reg_wdata[29:26];

  assign reg_rdata = reg_sel ? {go, wr_dir, ack, 3'b000, ra, pa, dat}
                             : {~go, en, 10'd0, flt, flt_en, 2'b00, div};
  assign mdc     = mdc_q;
  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      flt    <= 1'b0;
      flt_en <= 1'b0;
      div    <= DIV_RST;
      go     <= 1'b0;
      wr_dir <= 1'b0;
      ack    <= 1'b0;
      ta_smp <= 1'b1;
      ra     <= '0;
      pa     <= '0;
      dat    <= '0;
      rd     <= '0;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '1;
      mdc_q  <= 1'b0;
      mdo_q  <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en     <= reg_wdata[30];
        flt_en <= reg_wdata[18];
        div    <= reg_wdata[15:0];
      end
      if (rise && oe_q && flt_en && (mdio_i != mdo_q))
        flt <= 1'b1;
      else if (ctrl_wr && reg_wdata[19])
        flt <= 1'b0;

      if (usr_wr) begin
        wr_dir <= reg_wdata[30];
        ra     <= reg_wdata[25:21];
        pa     <= reg_wdata[20:16];
        dat    <= reg_wdata[15:0];
      end

      if (start) begin
        go    <= 1'b1;
        cnt   <= '0;
        idx   <= '0;
        rd    <= '0;
        sh    <= {32'hFFFF_FFFF, 2'b01,
                  reg_wdata[30] ? 2'b01 : 2'b10,
                  reg_wdata[20:16], reg_wdata[25:21],
                  reg_wdata[30] ? 2'b10 : 2'b11,
                  reg_wdata[30] ? reg_wdata[15:0] : 16'hFFFF};
        mdc_q <= 1'b0;
        mdo_q <= 1'b1;
        oe_q  <= 1'b1;
      end else if (go && !en) begin
        go    <= 1'b0;
        mdc_q <= 1'b0;
        oe_q  <= 1'b0;
        mdo_q <= 1'b1;
      end else if (go) begin
        cnt <= fall ? 16'd0 : cnt + 16'd1;
        if (rise) begin
          mdc_q <= 1'b1;
          if (!wr_dir && idx == TA2_IDX) ta_smp <= mdio_i;
          if (!wr_dir && idx >= DATA_IDX) rd <= {rd[14:0], mdio_i};
        end
        if (fall) begin
          mdc_q <= 1'b0;
          if (idx == LAST_IDX) begin
            go    <= 1'b0;
            oe_q  <= 1'b0;
            mdo_q <= 1'b1;
            if (!wr_dir) begin
              dat <= rd;
              ack <= ~ta_smp;
            end
          end else begin
            idx   <= idx + 6'd1;
            sh    <= {sh[62:0], 1'b1};
            mdo_q <= sh[62];
            oe_q  <= wr_dir | (idx < REL_IDX - 6'd1);
          end
        end
      end
    end
  end

  a_r9_mdc_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc_q);

  a_r5_mdc_low_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !mdc_q);

  a_r6_data_moves_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdo_q) |-> !mdc_q);

  a_r7_read_releases_line: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wr_dir && idx >= REL_IDX) |-> !oe_q);

  a_r8_fields_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(go) && go) |-> ($stable(ra) && $stable(pa) && $stable(wr_dir)));

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flt) && !$past(ctrl_wr && reg_wdata[19])) |-> flt);

endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_on = 1'b0;
  logic [15:0] phy_data = '0;
  logic        phy_val = 1'b1;
  logic        clash = 1'b0;

  int checks = 0;
  int failures = 0;
  int mon_n = 0;
  int rise_total = 0;
  logic [63:0] mon_bits = '0;
  logic [63:0] mon_oe = '0;

  typedef struct {
    logic [63:0] bits;
    logic [63:0] mask;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  assign mdio_i = mdio_oe ? (mdio_o & ~clash) : phy_val;

  mdio_mgmt_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  always @(posedge mdc) begin
    exp_t e;
    mon_bits = {mon_bits[62:0], mdio_o};
    mon_oe   = {mon_oe[62:0], mdio_oe};
    mon_n++;
    rise_total++;
    if (mon_n == 64) begin
      mon_n = 0;
      if (sb_q.size() == 0) begin
        check("R4 unexpected frame", 64'd1, 64'd0);
      end else begin
        e = sb_q.pop_front();
        check("R4 frame bits", mon_bits & e.mask, e.bits & e.mask);
        check("R7 output enable pattern", mon_oe, e.mask);
      end
    end
  end

  always @(negedge mdc) begin
    if (!phy_on) phy_val = 1'b1;
    else if (mon_n == 47) phy_val = 1'b0;
    else if (mon_n >= 48 && mon_n <= 63) phy_val = phy_data[63 - mon_n];
    else phy_val = 1'b1;
  end

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic push_frame(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] d);
    exp_t e;
    e.bits = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, pa, ra,
              wr ? 2'b10 : 2'b00, wr ? d : 16'h0000};
    e.mask = wr ? {64{1'b1}} : {{46{1'b1}}, 18'd0};
    sb_q.push_back(e);
    reg_write(1'b1, {1'b1, wr, 4'b0000, ra, pa, d});
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    bit done = 0;
    for (int i = 0; i < 40000 && !done; i++) begin
      reg_read(1'b1, v);
      if (!v[31]) done = 1;
    end
    check({req, " go clears at frame end"}, 64'(done), 64'd1);
  endtask

  task automatic measure_period(input string req, input int exp_clks);
    realtime t0;
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc);
    check(req, 64'(int'(($realtime - t0) / 4.0)), 64'(exp_clks));
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        held;
    int          r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    reg_read(1'b0, v); check("R1 control reset value", 64'(v), 64'h8000_00FF);
    reg_read(1'b1, v); check("R1 user reset value", 64'(v), 64'h0);
    check("R1 mdc/oe low after reset", {62'd0, mdc, mdio_oe}, 64'd0);

    r0 = rise_total;
    reg_write(1'b1, 32'hC000_1234);
    reg_read(1'b1, v); check("R9 go ignored while disabled", 64'(v[31]), 64'd0);
    repeat (50) @(negedge clk);
    check("R9 mdc idle while disabled", 64'(rise_total - r0), 64'd0);

    reg_write(1'b0, 32'h4000_0003);
    reg_read(1'b0, v); check("R2 control readback", 64'(v), 64'hC000_0003);

    push_frame(1'b1, 5'h11, 5'h0A, 16'hBEEF);
    reg_read(1'b1, v); check("R3 go high during frame", 64'(v[31]), 64'd1);
    reg_read(1'b0, v); check("R3 idle low during frame", 64'(v[31]), 64'd0);
    reg_write(1'b1, 32'hC3FF_5555);
    measure_period("R5 period divider 3", 4);
    @(posedge mdc); v[0] = mdio_o; held = 1'b1;
    while (mdc) begin @(negedge clk); if (mdc && mdio_o !== v[0]) held = 1'b0; end
    check("R6 mdio steady while mdc high", 64'(held), 64'd1);
    wait_done("R3");
    reg_read(1'b1, v);
    check("R8 busy write ignored", 64'(v), 64'({1'b0, 1'b1, 1'b0, 3'b000, 5'h0A, 5'h11, 16'hBEEF}));
    reg_read(1'b0, v); check("R3 idle back high", 64'(v[31]), 64'd1);

    phy_on = 1'b1; phy_data = 16'h1234;
    push_frame(1'b0, 5'h03, 5'h02, 16'h0000);
    wait_done("R7");
    reg_read(1'b1, v);
    check("R7 read data", 64'(v[15:0]), 64'h1234);
    check("R7 ack on answer", 64'(v[29]), 64'd1);

    phy_on = 1'b0;
    push_frame(1'b0, 5'h1F, 5'h1F, 16'h0000);
    wait_done("R7");
    reg_read(1'b1, v);
    check("R7 no ack when silent", 64'(v[29]), 64'd0);
    check("R7 silent read data", 64'(v[15:0]), 64'hFFFF);

    reg_write(1'b0, 32'h4000_0000);
    push_frame(1'b1, 5'h01, 5'h02, 16'hA5A5);
    measure_period("R5 period divider 0", 2);
    wait_done("R5");

    reg_write(1'b0, 32'h4004_0003);
    push_frame(1'b1, 5'h04, 5'h05, 16'h0F0F);
    clash = 1'b1; repeat (20) @(negedge clk); clash = 1'b0;
    wait_done("R10");
    reg_read(1'b0, v); check("R10 fault captured", 64'(v[19]), 64'd1);
    reg_write(1'b0, 32'h400C_0003);
    reg_read(1'b0, v); check("R10 fault write-one clear", 64'(v[19]), 64'd0);
    reg_write(1'b0, 32'h4000_0003);
    push_frame(1'b1, 5'h04, 5'h05, 16'h0F0F);
    clash = 1'b1; repeat (20) @(negedge clk); clash = 1'b0;
    wait_done("R10");
    reg_read(1'b0, v); check("R10 no fault when detect off", 64'(v[19]), 64'd0);

    reg_write(1'b1, 32'hC000_0001);
    repeat (30) @(negedge clk);
    reg_write(1'b0, 32'h0000_0003);
    @(negedge clk);
    check("R9 abort mdc/oe low", {62'd0, mdc, mdio_oe}, 64'd0);
    reg_read(1'b1, v); check("R9 abort clears go", 64'(v[31]), 64'd0);
    reg_read(1'b0, v); check("R9 idle after abort", 64'(v[31]), 64'd1);
    mon_n = 0;

    reg_write(1'b0, 32'h4000_00FF);
    push_frame(1'b1, 5'h07, 5'h08, 16'h8001);
    measure_period("R5 period default divider", 256);
    wait_done("R5");
    repeat (4) @(negedge clk);
    check("R4 all frames seen", 64'(sb_q.size()), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule